// File: doc/BRIEF.md
# Linear Page-Table Address Translator

This block turns a virtual address into a physical address for a small paged memory system. A requester presents a virtual address together with an access kind (read, write or execute) over a valid/ready handshake. The block splits the address into a page number and a byte offset. It fetches the page-table entry for that page from a linear table kept in ordinary physical memory, through its own memory port. It then checks the entry and replies either with the physical address or with a fault and a cause code.

The table base is a writable register, loaded by software on each process switch, so each process can own a separate table. Each entry is one 32-bit word (4 bytes). Every translation costs one memory read. A permitted write to a page whose entry is still clean costs one more memory access: the entry is written back with its modified flag set before the reply is given. The block handles one request at a time and holds its reply until the requester takes it.

Top module: `pt_xlate`

## Requirements
- R1: The virtual address is 6 bits. Bits [5:4] are the page number and bits [3:0] are the byte offset. On success the 7-bit physical address is {entry bits [2:0], offset}, so the offset passes through unchanged.
- R2: The entry is read from byte address base + 4 × page number, taken modulo 128. The base is loaded from `base_wdata` on a cycle where `base_we` is high. Each translation issues exactly one memory read.
- R3: If entry bit 3 (mapping valid) is clear, the reply is a fault with cause 1.
- R4: If the entry is valid but bit 4 (resident) is clear, the reply is a fault with cause 2.
- R5: Access kinds are encoded as 0 read, 1 write, 2 execute and 3 reserved. Kinds 0, 1 and 2 are allowed by entry bits 5, 6 and 7 respectively. Kind 3 is never allowed. A valid, resident entry that does not allow the access gives a fault with cause 3.
- R6: The checks have a fixed priority: the mapping-valid check first, then the resident check, then the permission check. Only the cause of the first failing check is reported.
- R7: A fault reply carries physical address 0 and a non-zero cause. A successful reply has `rsp_fault` low and cause 0.
- R8: A permitted write whose entry has bit 8 (modified) clear causes a memory write of the same entry, with bit 8 set, to the same address, before the reply. No other translation writes memory.
- R9: `req_ready` is high only while the block is idle. The block does no memory traffic and presents no reply while idle. A reply stays valid and unchanged until `rsp_ready` is seen high.
- R10: After reset, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low.
- R11: A memory request stays valid, with a stable address and direction, until `mem_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 7 | New table base byte address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 6 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Reply valid |
| rsp_ready | input | 1 | Requester takes the reply |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 unmapped, 2 not resident, 3 not permitted |
| rsp_paddr | output | 7 | Physical address (0 on a fault) |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 7 | Entry byte address |
| mem_req_wdata | output | 32 | Entry written back with the modified flag set |
| mem_rsp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
Some properties are checked on every cycle by the assertions:
- a fault never comes with a non-zero address or a zero cause;
- a successful reply keeps the requested offset;
- replies and stalled memory requests hold steady until they are taken;
- the idle state is quiet;
- every write-back carries the modified flag.

Other behaviour can only be shown by the directed scenarios, which compare against a model built from the requirements. These are the mapping through the table, the base offset and its wraparound, the cause chosen for each mix of entry bits and access kind, and the count of reads and writes per translation. The scenarios also show that the write-back reaches memory exactly once per clean page.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_UNMAPPED = 2'd1,
    CAUSE_ABSENT  = 2'd2,
    CAUSE_DENIED  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWAIT,
    ST_CHECK,
    ST_WBACK,
    ST_WWAIT,
    ST_REPLY
  } xl_state_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int VPN_W       = 2,
  parameter int PA_W        = 7,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int SH = $clog2(ENTRY_BYTES);

  // Linear table: one entry per page, entries packed back to back.
  assign addr_o = base_i + (PA_W'(vpn_i) << SH);
endmodule

// File: rtl/pt_check.sv
module pt_check
  import pt_pkg::*;
#(
  parameter int PPN_W = 3,
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  acc_e             acc_i,
  output cause_e           cause_o,
  output logic             need_wb_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [PTE_W-1:0] pte_dirty_o
);
  localparam int B_VALID = PPN_W;
  localparam int B_RES   = PPN_W + 1;
  localparam int B_PERM  = PPN_W + 2;
  localparam int N_PERM  = 3;
  localparam int B_DIRTY = PPN_W + 5;

  logic [N_PERM-1:0] perm;
  logic              allowed;

  genvar g;
  generate
    for (g = 0; g < N_PERM; g++) begin : g_perm
      assign perm[g] = pte_i[B_PERM+g];
    end
  endgenerate

  always_comb begin
    allowed = 1'b0;
    for (int k = 0; k < N_PERM; k++) begin
      if (acc_i == acc_e'(k)) allowed = perm[k];
    end
  end

  always_comb begin
    if (!pte_i[B_VALID])    cause_o = CAUSE_UNMAPPED;
    else if (!pte_i[B_RES]) cause_o = CAUSE_ABSENT;
    else if (!allowed)      cause_o = CAUSE_DENIED;
    else                    cause_o = CAUSE_NONE;
  end

  assign need_wb_o   = (cause_o == CAUSE_NONE) && (acc_i == ACC_WRITE) && !pte_i[B_DIRTY];
  assign ppn_o       = pte_i[PPN_W-1:0];
  assign pte_dirty_o = pte_i | (PTE_W'(1) << B_DIRTY);
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  output logic req_ready_o,
  input  logic need_wb_i,
  input  logic mem_ready_i,
  input  logic mem_rsp_i,
  output logic mem_valid_o,
  output logic mem_we_o,
  output logic rsp_valid_o,
  input  logic rsp_ready_i,
  output logic ld_req_o,
  output logic ld_pte_o,
  output logic ld_res_o
);
  xl_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    req_ready_o = 1'b0;
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    rsp_valid_o = 1'b0;
    ld_req_o    = 1'b0;
    ld_pte_o    = 1'b0;
    ld_res_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) begin
          ld_req_o = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_valid_o = 1'b1;
        if (mem_ready_i) state_d = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (mem_rsp_i) begin
          ld_pte_o = 1'b1;
          state_d  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        ld_res_o = 1'b1;
        state_d  = need_wb_i ? ST_WBACK : ST_REPLY;
      end
      ST_WBACK: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        if (mem_ready_i) state_d = ST_WWAIT;
      end
      ST_WWAIT: begin
        if (mem_rsp_i) state_d = ST_REPLY;
      end
      ST_REPLY: begin
        rsp_valid_o = 1'b1;
        if (rsp_ready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9: idle means no memory traffic and no reply
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (!mem_valid_o && !rsp_valid_o));

  // R11: a stalled memory request keeps its direction
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_we_o)));
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_pkg::*;
#(
  parameter int OFF_W       = 4,
  parameter int VPN_W       = 2,
  parameter int PPN_W       = 3,
  parameter int PTE_W       = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    base_we,
  input  logic [PPN_W+OFF_W-1:0]  base_wdata,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VPN_W+OFF_W-1:0]  req_vaddr,
  input  logic [1:0]              req_acc,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_cause,
  output logic [PPN_W+OFF_W-1:0]  rsp_paddr,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_we,
  output logic [PPN_W+OFF_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0]        mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [PTE_W-1:0]        mem_rsp_rdata
);
  localparam int VA_W    = VPN_W + OFF_W;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int B_DIRTY = PPN_W + 5;

  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  vaddr_q;
  acc_e             acc_q;
  logic [PTE_W-1:0] pte_q;
  logic             fault_q;
  cause_e           cause_q;
  logic [PA_W-1:0]  paddr_q;

  logic             ld_req, ld_pte, ld_res, need_wb;
  cause_e           cause_w;
  logic [PPN_W-1:0] ppn_w;
  logic [PTE_W-1:0] pte_dirty_w;

  pt_entry_addr #(.VPN_W(VPN_W), .PA_W(PA_W), .ENTRY_BYTES(ENTRY_BYTES)) u_eaddr (
    .base_i (base_q),
    .vpn_i  (vaddr_q[VA_W-1:OFF_W]),
    .addr_o (mem_req_addr)
  );

  pt_check #(.PPN_W(PPN_W), .PTE_W(PTE_W)) u_check (
    .pte_i       (pte_q),
    .acc_i       (acc_q),
    .cause_o     (cause_w),
    .need_wb_o   (need_wb),
    .ppn_o       (ppn_w),
    .pte_dirty_o (pte_dirty_w)
  );

  pt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .need_wb_i   (need_wb),
    .mem_ready_i (mem_req_ready),
    .mem_rsp_i   (mem_rsp_valid),
    .mem_valid_o (mem_req_valid),
    .mem_we_o    (mem_req_we),
    .rsp_valid_o (rsp_valid),
    .rsp_ready_i (rsp_ready),
    .ld_req_o    (ld_req),
    .ld_pte_o    (ld_pte),
    .ld_res_o    (ld_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      acc_q   <= ACC_READ;
    end else if (ld_req) begin
      vaddr_q <= req_vaddr;
      acc_q   <= acc_e'(req_acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pte_q <= '0;
    else if (ld_pte) pte_q <= mem_rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      paddr_q <= '0;
    end else if (ld_res) begin
      fault_q <= (cause_w != CAUSE_NONE);
      cause_q <= cause_w;
      paddr_q <= (cause_w != CAUSE_NONE) ? '0 : {ppn_w, vaddr_q[OFF_W-1:0]};
    end
  end

  assign mem_req_wdata = mem_req_we ? pte_dirty_w : '0;
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
  assign rsp_paddr     = paddr_q;

  // R7: a fault carries no address and a real cause
  a_r7_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cause != 2'd0));

  // R1, R7: success keeps the requested offset and reports no cause
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0 &&
      rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  // R9: reply held until taken
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
      $stable(rsp_cause) && $stable(rsp_fault)));

  // R11: stalled memory request keeps its address
  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  // R8: every write-back marks the entry modified
  a_r8_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[B_DIRTY]);
endmodule

// File: tb/pt_xlate_tb.sv
`timescale 1ns/1ps
module pt_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_we;
  logic [6:0]  base_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [5:0]  req_vaddr;
  logic [1:0]  req_acc;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [6:0]  rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [6:0]  mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] mem [32];
  bit stall_mode = 0;
  logic stall_tgl;
  logic [6:0] last_wr_addr;

  always #4 clk = ~clk;

  pt_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // Memory model: word array, one-cycle response, optional stalls
  assign mem_req_ready = stall_mode ? stall_tgl : 1'b1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      stall_tgl     <= 1'b0;
    end else begin
      stall_tgl     <= ~stall_tgl;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_we) begin
          mem[mem_req_addr[6:2]] = mem_req_wdata;
          last_wr_addr = mem_req_addr;
          wr_cnt = wr_cnt + 1;
        end else begin
          mem_rsp_rdata <= mem[mem_req_addr[6:2]];
          rd_cnt = rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Entry: [2:0] ppn, 3 valid, 4 resident, 5 read, 6 write, 7 exec, 8 modified
  function automatic logic [31:0] mk(input int ppn, input bit v, input bit p,
                                     input bit r, input bit w, input bit x, input bit d);
    return 32'(ppn & 7) | (32'(v) << 3) | (32'(p) << 4) | (32'(r) << 5) |
           (32'(w) << 6) | (32'(x) << 7) | (32'(d) << 8);
  endfunction

  task automatic set_base(input logic [6:0] b);
    @(negedge clk); base_we = 1'b1; base_wdata = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic put_pte(input logic [6:0] b, input int vpn, input logic [31:0] v);
    logic [6:0] a;
    a = b + 7'(vpn * 4);
    mem[a[6:2]] = v;
  endtask

  // Translate and compare against a model of the requirements
  task automatic xlate(input logic [6:0] b, input logic [5:0] va, input logic [1:0] acc,
                       input string req, input int hold_cycles);
    logic [6:0] ea;
    logic [31:0] pte;
    int exp_cause, exp_pa, exp_wb, r0, w0;
    bit allowed;
    ea  = b + 7'(int'(va[5:4]) * 4);
    pte = mem[ea[6:2]];
    allowed = (acc == 2'd0) ? pte[5] : (acc == 2'd1) ? pte[6] : (acc == 2'd2) ? pte[7] : 1'b0;
    if (!pte[3])      exp_cause = 1;
    else if (!pte[4]) exp_cause = 2;
    else if (!allowed) exp_cause = 3;
    else              exp_cause = 0;
    exp_pa = (exp_cause != 0) ? 0 : int'({pte[2:0], va[3:0]});
    exp_wb = (exp_cause == 0 && acc == 2'd1 && !pte[8]) ? 1 : 0;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_cause == 2'(exp_cause), req, "cause", rsp_cause, exp_cause);
    chk(rsp_fault == (exp_cause != 0), req, "fault", rsp_fault, exp_cause != 0);
    chk(rsp_paddr == 7'(exp_pa), req, "paddr", rsp_paddr, exp_pa);
    chk(rd_cnt - r0 == 1, "R2", "reads per translation", rd_cnt - r0, 1);
    chk(wr_cnt - w0 == exp_wb, "R8", "write-backs", wr_cnt - w0, exp_wb);
    if (exp_wb == 1) begin
      chk(mem[ea[6:2]] == (pte | 32'h100), "R8", "entry after write-back", mem[ea[6:2]], pte | 32'h100);
      chk(last_wr_addr == ea, "R8", "write-back address", last_wr_addr, ea);
    end
    for (int i = 0; i < hold_cycles; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == 7'(exp_pa) && rsp_cause == 2'(exp_cause),
          "R9", "reply held", rsp_paddr, exp_pa);
      chk(!req_ready, "R9", "busy while replying", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R9", "idle after reply taken", req_ready, 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R10", "mem_req_valid after reset", mem_req_valid, 0);
  endtask

  task automatic t_mapping();
    // pages 0..3 -> frames 3,7,5,2, fully permitted and modified
    put_pte(7'd0, 0, mk(3, 1, 1, 1, 1, 1, 1));
    put_pte(7'd0, 1, mk(7, 1, 1, 1, 1, 1, 1));
    put_pte(7'd0, 2, mk(5, 1, 1, 1, 1, 1, 1));
    put_pte(7'd0, 3, mk(2, 1, 1, 1, 1, 1, 1));
    xlate(7'd0, 6'd20, 2'd0, "R1", 0);
    xlate(7'd0, 6'd0,  2'd2, "R1", 0);
    xlate(7'd0, 6'd63, 2'd1, "R1", 0);
    xlate(7'd0, 6'd41, 2'd0, "R1", 0);
  endtask

  task automatic t_faults();
    set_base(7'd64);
    put_pte(7'd64, 0, mk(1, 0, 1, 1, 1, 1, 1));  // unmapped
    put_pte(7'd64, 1, mk(4, 1, 0, 1, 1, 1, 1));  // not resident
    put_pte(7'd64, 2, mk(6, 1, 1, 1, 0, 0, 1));  // read only
    put_pte(7'd64, 3, mk(0, 1, 1, 0, 0, 1, 1));  // execute only
    xlate(7'd64, 6'h05, 2'd0, "R3", 0);
    xlate(7'd64, 6'h1a, 2'd2, "R4", 0);
    xlate(7'd64, 6'h2c, 2'd1, "R5", 0);
    xlate(7'd64, 6'h2c, 2'd0, "R5", 0);
    xlate(7'd64, 6'h31, 2'd0, "R5", 0);
    xlate(7'd64, 6'h31, 2'd2, "R5", 0);
    xlate(7'd64, 6'h2c, 2'd3, "R5", 0);
  endtask

  task automatic t_priority();
    put_pte(7'd64, 0, mk(2, 0, 0, 0, 0, 0, 0));  // every check fails -> unmapped
    put_pte(7'd64, 1, mk(2, 1, 0, 0, 0, 0, 0));  // resident and perm fail -> absent
    xlate(7'd64, 6'h03, 2'd1, "R6", 0);
    xlate(7'd64, 6'h13, 2'd1, "R6", 0);
    xlate(7'd64, 6'h03, 2'd3, "R6", 0);
  endtask

  task automatic t_dirty();
    set_base(7'd32);
    put_pte(7'd32, 0, mk(6, 1, 1, 1, 1, 0, 0));
    put_pte(7'd32, 1, mk(1, 1, 1, 1, 1, 0, 0));
    xlate(7'd32, 6'h07, 2'd0, "R8", 0);   // clean read: no write-back
    xlate(7'd32, 6'h07, 2'd1, "R8", 0);   // clean write: write-back
    xlate(7'd32, 6'h08, 2'd1, "R8", 0);   // now modified: no write-back
    put_pte(7'd32, 2, mk(1, 1, 1, 1, 0, 0, 0));
    xlate(7'd32, 6'h22, 2'd1, "R8", 0);   // denied write: no write-back
    xlate(7'd32, 6'h1f, 2'd1, "R8", 0);
  endtask

  task automatic t_base_wrap();
    set_base(7'd124);                     // page 1 wraps to address 0
    put_pte(7'd124, 0, mk(4, 1, 1, 1, 0, 0, 1));
    put_pte(7'd124, 1, mk(5, 1, 1, 1, 0, 0, 1));
    xlate(7'd124, 6'h0e, 2'd0, "R2", 0);
    xlate(7'd124, 6'h1e, 2'd0, "R2", 0);
    chk(mem[0] == mk(5, 1, 1, 1, 0, 0, 1), "R2", "wrapped entry slot", mem[0], mk(5, 1, 1, 1, 0, 0, 1));
  endtask

  task automatic t_stall_hold();
    stall_mode = 1;
    set_base(7'd16);
    put_pte(7'd16, 2, mk(3, 1, 1, 1, 1, 1, 0));
    xlate(7'd16, 6'h2a, 2'd1, "R11", 3);
    xlate(7'd16, 6'h25, 2'd2, "R11", 2);
    stall_mode = 0;
    xlate(7'd16, 6'h20, 2'd0, "R9", 4);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    rst_n = 1'b0; base_we = 1'b0; base_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_acc = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_faults();
    t_priority();
    t_dirty();
    t_base_wrap();
    t_stall_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule